// File: doc/BRIEF.md
# Stuck-at Suspect Evidence Scorer

This block grades one stuck-at suspect against the behaviour of a failing device, pattern by pattern. For every applied test pattern it takes three response vectors of equal width: what the device actually produced, what a fault-free circuit produces, and what the circuit produces with the suspect fault injected. An output is a failure when it differs from the fault-free value. From the two resulting failure vectors the block forms four per-pattern counts. Matched failures are outputs where both the device and the suspect fail. Induced failures are outputs where the suspect fails but the device is correct. Missed failures are outputs where the device fails but the suspect does not. The fourth count is the smaller of the matched and induced counts. The counts are also added into running totals.

A diagnosis controller streams the response triples in, one per valid cycle, and reads back two things. The first is a fault-model class derived from the totals. The second is an ordering of this suspect against a peer suspect whose totals are presented on a separate port. A suspect with more matched failures ranks higher, and among equals the one with fewer induced failures ranks higher. A synchronous clear starts a new pattern set.

Top module: `evid_scorer`

## Requirements
- R1: One cycle after `in_vld` is high, `pat_vld` is high and `pat_alpha`, `pat_iota`, `pat_tau` hold the popcounts of (obs^good)&(flt^good), (flt^good)&~(obs^good) and (obs^good)&~(flt^good) of the sampled inputs. One cycle after `in_vld` is low, `pat_vld` is low.
- R2: While `pat_vld` is high, `pat_gamma` equals the smaller of `pat_alpha` and `pat_iota`.
- R3: `pat_full` is high exactly when `pat_vld` is high, `pat_alpha` > 0 and `pat_iota` = `pat_tau` = 0.
- R4: On the clock edge after a cycle with `pat_vld` high, each total grows by its per-pattern count. With `pat_vld` low and `clr` low, all totals hold.
- R5: A total whose sum would exceed 2^TOT_W-1 stays at 2^TOT_W-1 and never wraps.
- R6: `clr` high at a clock edge makes all four totals zero after that edge. Any staged pattern is discarded, and `clr` takes priority over an addition.
- R7: While `rst_n` is low, `pat_vld`, `pat_full` and all totals are zero.
- R8: With `tot_alpha` > 0, `fault_class` is 1 when iota, tau and gamma totals are all zero. It is 2 when only tau is nonzero, 3 when only iota is nonzero, 4 when iota and tau are nonzero with gamma zero, 5 when iota and gamma are nonzero with tau zero, and 6 when iota, tau and gamma are all nonzero.
- R9: With `tot_alpha` = 0, `fault_class` is 0 (no evidence).
- R10: `rank` is 2'b01 when `tot_alpha` > `peer_alpha`, or when they are equal and `tot_iota` < `peer_iota`. It is 2'b10 in the mirror cases, and 2'b00 when both alpha and iota are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the totals |
| in_vld | input | 1 | Response triple valid |
| obs_resp | input | N | Observed device response |
| good_resp | input | N | Fault-free response |
| flt_resp | input | N | Response with suspect fault injected |
| pat_vld | output | 1 | Per-pattern counts valid |
| pat_alpha | output | CNT_W | Matched failures of the last pattern |
| pat_iota | output | CNT_W | Induced failures of the last pattern |
| pat_tau | output | CNT_W | Missed failures of the last pattern |
| pat_gamma | output | CNT_W | min(alpha, iota) of the last pattern |
| pat_full | output | 1 | Last pattern fully explained |
| tot_alpha | output | TOT_W | Running matched total |
| tot_iota | output | TOT_W | Running induced total |
| tot_tau | output | TOT_W | Running missed total |
| tot_gamma | output | TOT_W | Running gamma total |
| fault_class | output | 3 | Fault-model class code |
| peer_alpha | input | TOT_W | Peer suspect matched total |
| peer_iota | input | TOT_W | Peer suspect induced total |
| rank | output | 2 | Ordering against the peer |

## Verification
The assertions assume that the control inputs `in_vld` and `clr` are never unknown once reset is released. They also assume that the peer totals are steady between the edges the bench samples on. The bench drives every input shortly after a rising edge and holds it there until the next one, so the values seen at each edge are fully defined. The random phase runs with a narrowed total width so that saturation can be reached. Directed patterns then build each class code from small known failure masks.

// File: rtl/evid_pkg.sv
package evid_pkg;
   typedef enum logic [2:0] {
      CLS_NONE   = 3'd0,
      CLS_SSA    = 3'd1,
      CLS_MSA    = 3'd2,
      CLS_CSA    = 3'd3,
      CLS_MCSA   = 3'd4,
      CLS_DELAY  = 3'd5,
      CLS_UNEXPL = 3'd6
   } fclass_e;

   typedef enum logic [1:0] {
      RANK_TIE  = 2'b00,
      RANK_SELF = 2'b01,
      RANK_PEER = 2'b10
   } rank_e;

   localparam int NCOMP = 4;  // alpha, iota, tau, gamma
endpackage

// File: rtl/evid_popcnt.sv
module evid_popcnt #(
   parameter int W  = 32,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < W; i++)
         cnt = cnt + {{(CW-1){1'b0}}, vec[i]};
   end
endmodule

// File: rtl/evid_pattern_eval.sv
module evid_pattern_eval #(
   parameter int N  = 32,
   parameter int CW = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [N-1:0]  obs,
   input  logic [N-1:0]  good,
   input  logic [N-1:0]  flt,
   output logic          pat_vld,
   output logic [CW-1:0] alpha,
   output logic [CW-1:0] iota,
   output logic [CW-1:0] tau,
   output logic [CW-1:0] gamma,
   output logic          full
);
   logic [N-1:0]  dev_fail, sus_fail;
   logic [N-1:0]  v_match, v_induce, v_miss;
   logic [CW-1:0] c_a, c_i, c_t, c_g;

   assign dev_fail = obs ^ good;
   assign sus_fail = flt ^ good;
   assign v_match  = dev_fail & sus_fail;
   assign v_induce = sus_fail & ~dev_fail;
   assign v_miss   = dev_fail & ~sus_fail;

   evid_popcnt #(.W(N), .CW(CW)) u_pa (.vec(v_match),  .cnt(c_a));
   evid_popcnt #(.W(N), .CW(CW)) u_pi (.vec(v_induce), .cnt(c_i));
   evid_popcnt #(.W(N), .CW(CW)) u_pt (.vec(v_miss),   .cnt(c_t));

   assign c_g = (c_a < c_i) ? c_a : c_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_vld <= 1'b0;
         full    <= 1'b0;
         alpha   <= '0;
         iota    <= '0;
         tau     <= '0;
         gamma   <= '0;
      end else begin
         pat_vld <= in_vld;
         full    <= in_vld && (c_a != '0) && (c_i == '0) && (c_t == '0);
         if (in_vld) begin
            alpha <= c_a;
            iota  <= c_i;
            tau   <= c_t;
            gamma <= c_g;
         end
      end
   end
endmodule

// File: rtl/evid_sat_acc.sv
module evid_sat_acc #(
   parameter int CW = 6,
   parameter int TW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          add_en,
   input  logic [CW-1:0] inc,
   output logic [TW-1:0] total
);
   localparam logic [TW-1:0] TMAX = {TW{1'b1}};
   logic [TW:0] sum;

   assign sum = {1'b0, total} + {{(TW+1-CW){1'b0}}, inc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         total <= '0;
      else if (clr)
         total <= '0;
      else if (add_en)
         total <= sum[TW] ? TMAX : sum[TW-1:0];
   end
endmodule

// File: rtl/evid_judge.sv
module evid_judge
   import evid_pkg::*;
#(
   parameter int TW = 20
) (
   input  logic [TW-1:0] t_alpha,
   input  logic [TW-1:0] t_iota,
   input  logic [TW-1:0] t_tau,
   input  logic [TW-1:0] t_gamma,
   input  logic [TW-1:0] p_alpha,
   input  logic [TW-1:0] p_iota,
   output fclass_e       cls,
   output rank_e         rnk
);
   logic nz_i, nz_t, nz_g;
   assign nz_i = (t_iota  != '0);
   assign nz_t = (t_tau   != '0);
   assign nz_g = (t_gamma != '0);

   always_comb begin
      if (t_alpha == '0)
         cls = CLS_NONE;
      else begin
         unique case ({nz_i, nz_t, nz_g})
            3'b000:  cls = CLS_SSA;
            3'b010:  cls = CLS_MSA;
            3'b100:  cls = CLS_CSA;
            3'b110:  cls = CLS_MCSA;
            3'b101:  cls = CLS_DELAY;
            default: cls = CLS_UNEXPL;
         endcase
      end
   end

   always_comb begin
      if (t_alpha > p_alpha)      rnk = RANK_SELF;
      else if (t_alpha < p_alpha) rnk = RANK_PEER;
      else if (t_iota < p_iota)   rnk = RANK_SELF;
      else if (t_iota > p_iota)   rnk = RANK_PEER;
      else                        rnk = RANK_TIE;
   end
endmodule

// File: rtl/evid_scorer.sv
module evid_scorer
   import evid_pkg::*;
#(
   parameter int N     = 32,
   parameter int TOT_W = 20,
   localparam int CNT_W = $clog2(N + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_vld,
   input  logic [N-1:0]     obs_resp,
   input  logic [N-1:0]     good_resp,
   input  logic [N-1:0]     flt_resp,
   output logic             pat_vld,
   output logic [CNT_W-1:0] pat_alpha,
   output logic [CNT_W-1:0] pat_iota,
   output logic [CNT_W-1:0] pat_tau,
   output logic [CNT_W-1:0] pat_gamma,
   output logic             pat_full,
   output logic [TOT_W-1:0] tot_alpha,
   output logic [TOT_W-1:0] tot_iota,
   output logic [TOT_W-1:0] tot_tau,
   output logic [TOT_W-1:0] tot_gamma,
   output logic [2:0]       fault_class,
   input  logic [TOT_W-1:0] peer_alpha,
   input  logic [TOT_W-1:0] peer_iota,
   output logic [1:0]       rank
);
   generate
      if (N < 1) begin : g_bad_n
         $error("evid_scorer: N must be at least 1");
      end
      if (TOT_W < CNT_W) begin : g_bad_tw
         $error("evid_scorer: TOT_W must cover one pattern count");
      end
   endgenerate

   logic [NCOMP-1:0][CNT_W-1:0] inc;
   logic [NCOMP-1:0][TOT_W-1:0] tot;
   fclass_e cls;
   rank_e   rnk;

   evid_pattern_eval #(.N(N), .CW(CNT_W)) u_eval (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .obs(obs_resp), .good(good_resp), .flt(flt_resp),
      .pat_vld(pat_vld), .alpha(pat_alpha), .iota(pat_iota),
      .tau(pat_tau), .gamma(pat_gamma), .full(pat_full)
   );

   assign inc[0] = pat_alpha;
   assign inc[1] = pat_iota;
   assign inc[2] = pat_tau;
   assign inc[3] = pat_gamma;

   for (genvar k = 0; k < NCOMP; k++) begin : g_acc
      evid_sat_acc #(.CW(CNT_W), .TW(TOT_W)) u_acc (
         .clk(clk), .rst_n(rst_n), .clr(clr), .add_en(pat_vld),
         .inc(inc[k]), .total(tot[k])
      );
   end

   assign tot_alpha = tot[0];
   assign tot_iota  = tot[1];
   assign tot_tau   = tot[2];
   assign tot_gamma = tot[3];

   evid_judge #(.TW(TOT_W)) u_judge (
      .t_alpha(tot_alpha), .t_iota(tot_iota), .t_tau(tot_tau),
      .t_gamma(tot_gamma), .p_alpha(peer_alpha), .p_iota(peer_iota),
      .cls(cls), .rnk(rnk)
   );

   assign fault_class = cls;
   assign rank        = rnk;
endmodule

// File: rtl/evid_scorer_chk.sv
module evid_scorer_chk #(
   parameter int N     = 32,
   parameter int TOT_W = 20,
   localparam int CNT_W = $clog2(N + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             in_vld,
   input logic             pat_vld,
   input logic [CNT_W-1:0] pat_alpha,
   input logic [CNT_W-1:0] pat_iota,
   input logic [CNT_W-1:0] pat_tau,
   input logic [CNT_W-1:0] pat_gamma,
   input logic             pat_full,
   input logic [TOT_W-1:0] tot_alpha,
   input logic [TOT_W-1:0] tot_iota,
   input logic [TOT_W-1:0] tot_tau,
   input logic [TOT_W-1:0] tot_gamma,
   input logic [2:0]       fault_class,
   input logic [TOT_W-1:0] peer_alpha,
   input logic [1:0]       rank
);
   // R1
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> pat_vld);
   // R1
   vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !pat_vld);
   // R1
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_vld |-> (int'(pat_alpha) + int'(pat_tau) <= N) &&
                  (int'(pat_alpha) + int'(pat_iota) <= N));
   // R2
   gamma_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_vld |-> (pat_gamma <= pat_alpha) && (pat_gamma <= pat_iota) &&
                  ((pat_gamma == pat_alpha) || (pat_gamma == pat_iota)));
   // R3
   full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_full |-> pat_vld && (pat_alpha != '0) && (pat_iota == '0) && (pat_tau == '0));
   // R3
   full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_vld && (pat_alpha != '0) && (pat_iota == '0) && (pat_tau == '0)) |-> pat_full);
   // R4
   tot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !pat_vld) |=> $stable(tot_alpha) && $stable(tot_iota) &&
                             $stable(tot_tau) && $stable(tot_gamma));
   // R5
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (tot_alpha >= $past(tot_alpha)) && (tot_iota >= $past(tot_iota)) &&
               (tot_tau >= $past(tot_tau)) && (tot_gamma >= $past(tot_gamma)));
   // R6
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (tot_alpha == '0) && (tot_iota == '0) && (tot_tau == '0) && (tot_gamma == '0));
   // R8
   ssa_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tot_alpha != '0) && (tot_iota == '0) && (tot_tau == '0)) |-> (fault_class == 3'd1));
   // R9
   none_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tot_alpha == '0) |-> (fault_class == 3'd0));
   // R10
   rank_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tot_alpha > peer_alpha) |-> (rank == 2'b01));
endmodule

bind evid_scorer evid_scorer_chk #(.N(N), .TOT_W(TOT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld),
   .pat_vld(pat_vld), .pat_alpha(pat_alpha), .pat_iota(pat_iota),
   .pat_tau(pat_tau), .pat_gamma(pat_gamma), .pat_full(pat_full),
   .tot_alpha(tot_alpha), .tot_iota(tot_iota), .tot_tau(tot_tau),
   .tot_gamma(tot_gamma), .fault_class(fault_class),
   .peer_alpha(peer_alpha), .rank(rank)
);

// File: tb/sim_evid_scorer.sv
`timescale 1ns/1ps
module sim_evid_scorer;
   localparam int N    = 32;
   localparam int TW   = 12;
   localparam int CW   = $clog2(N + 1);
   localparam int TMAX = (1 << TW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          in_vld = 1'b0;
   logic [N-1:0]  obs = '0, good = '0, flt = '0;
   logic          pat_vld, pat_full;
   logic [CW-1:0] pat_alpha, pat_iota, pat_tau, pat_gamma;
   logic [TW-1:0] tot_alpha, tot_iota, tot_tau, tot_gamma;
   logic [TW-1:0] peer_alpha = '0, peer_iota = '0;
   logic [2:0]    fault_class;
   logic [1:0]    rank;

   int n_chk = 0, n_bad = 0;
   bit run_cmp = 1'b0;

   always #2.5 clk = ~clk;

   evid_scorer #(.N(N), .TOT_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld),
      .obs_resp(obs), .good_resp(good), .flt_resp(flt),
      .pat_vld(pat_vld), .pat_alpha(pat_alpha), .pat_iota(pat_iota),
      .pat_tau(pat_tau), .pat_gamma(pat_gamma), .pat_full(pat_full),
      .tot_alpha(tot_alpha), .tot_iota(tot_iota), .tot_tau(tot_tau),
      .tot_gamma(tot_gamma), .fault_class(fault_class),
      .peer_alpha(peer_alpha), .peer_iota(peer_iota), .rank(rank)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference
   int m_tot[4];
   int m_stg[4];
   bit m_pv, m_full;

   function automatic int ref_class(input int a, input int i, input int t, input int g);
      if (a == 0) return 0;
      if (i == 0 && t == 0 && g == 0) return 1;
      if (i == 0 && t != 0) return 2;
      if (i != 0 && t == 0 && g == 0) return 3;
      if (i != 0 && t != 0 && g == 0) return 4;
      if (i != 0 && t == 0 && g != 0) return 5;
      return 6;
   endfunction

   function automatic int ref_rank(input int a, input int i, input int pa, input int pi);
      if (a > pa) return 1;
      if (a < pa) return 2;
      if (i < pi) return 1;
      if (i > pi) return 2;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) begin m_tot[k] = 0; m_stg[k] = 0; end
         m_pv = 0; m_full = 0;
      end else begin
         if (clr)
            for (int k = 0; k < 4; k++) m_tot[k] = 0;
         else if (m_pv)
            for (int k = 0; k < 4; k++)
               m_tot[k] = (m_tot[k] + m_stg[k] > TMAX) ? TMAX : m_tot[k] + m_stg[k];
         m_pv = in_vld;
         m_full = 0;
         if (in_vld) begin
            logic [N-1:0] df, sf;
            df = obs ^ good;
            sf = flt ^ good;
            m_stg[0] = $countones(df & sf);
            m_stg[1] = $countones(sf & ~df);
            m_stg[2] = $countones(df & ~sf);
            m_stg[3] = (m_stg[0] < m_stg[1]) ? m_stg[0] : m_stg[1];
            m_full = (m_stg[0] > 0) && (m_stg[1] == 0) && (m_stg[2] == 0);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         check("R1 pat_vld", pat_vld, m_pv);
         if (m_pv) begin
            check("R1 pat_alpha", pat_alpha, m_stg[0]);
            check("R1 pat_iota", pat_iota, m_stg[1]);
            check("R1 pat_tau", pat_tau, m_stg[2]);
            check("R2 pat_gamma", pat_gamma, m_stg[3]);
         end
         check("R3 pat_full", pat_full, m_full);
         check("R4/R5 tot_alpha", tot_alpha, m_tot[0]);
         check("R4/R5 tot_iota", tot_iota, m_tot[1]);
         check("R4/R5 tot_tau", tot_tau, m_tot[2]);
         check("R4/R5 tot_gamma", tot_gamma, m_tot[3]);
         check("R8/R9 class", fault_class, ref_class(m_tot[0], m_tot[1], m_tot[2], m_tot[3]));
         check("R10 rank", rank, ref_rank(m_tot[0], m_tot[1], peer_alpha, peer_iota));
      end
   end

   task automatic drive(input logic [N-1:0] o, input logic [N-1:0] f);
      @(posedge clk); #1;
      in_vld = 1'b1; good = '0; obs = o; flt = f;
      @(posedge clk); #1;
      in_vld = 1'b0;
   endtask

   task automatic settle();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_clr();
      @(posedge clk); #1 clr = 1'b1;
      @(posedge clk); #1 clr = 1'b0;
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7 reset state
      check("R7 pat_vld", pat_vld, 0);
      check("R7 pat_full", pat_full, 0);
      check("R7 tot_alpha", tot_alpha, 0);
      check("R7 tot_iota", tot_iota, 0);
      check("R7 class", fault_class, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      run_cmp = 1'b1;

      // random triples
      for (int c = 0; c < 400; c++) begin
         @(posedge clk); #1;
         in_vld = ($urandom % 4) != 0;
         clr    = ($urandom % 60) == 0;
         good   = $urandom;
         flt    = good ^ ($urandom & $urandom & $urandom);
         obs    = ($urandom % 3 == 0) ? flt : good ^ ($urandom & $urandom);
         peer_alpha = TW'($urandom % 300);
         peer_iota  = TW'($urandom % 200);
      end
      @(posedge clk); #1 in_vld = 1'b0; clr = 1'b0;

      // R8 single stuck-at: fully explained
      do_clr();
      drive(32'h0000_000F, 32'h0000_000F);
      @(negedge clk);
      check("R3 full on explained pattern", pat_full, 1);
      settle();
      check("R8 class single stuck-at", fault_class, 1);
      // R10 ordering against a peer
      @(posedge clk); #1 peer_alpha = 3; peer_iota = 0;
      @(negedge clk) check("R10 larger alpha wins", rank, 1);
      @(posedge clk); #1 peer_alpha = 5;
      @(negedge clk) check("R10 smaller alpha loses", rank, 2);
      @(posedge clk); #1 peer_alpha = 4; peer_iota = 1;
      @(negedge clk) check("R10 alpha tie, fewer iota wins", rank, 1);
      @(posedge clk); #1 peer_iota = 0;
      @(negedge clk) check("R10 full tie", rank, 0);

      // R8 multiple sites: missed failures only
      do_clr();
      drive(32'h0000_00FF, 32'h0000_000F);
      settle();
      check("R8 class multi-site stuck-at", fault_class, 2);
      check("R4 tot_tau", tot_tau, 4);

      // R8 conditional: explained + induced on a passing pattern
      do_clr();
      drive(32'h0000_000F, 32'h0000_000F);
      drive(32'h0000_0000, 32'h0000_0003);
      settle();
      check("R8 class conditional stuck-at", fault_class, 3);
      check("R2 tot_gamma stays zero", tot_gamma, 0);
      @(posedge clk); #1 peer_alpha = 4; peer_iota = 1;
      @(negedge clk) check("R10 alpha tie, more iota loses", rank, 2);

      // R8 conditional multi-site
      do_clr();
      drive(32'h0000_00FF, 32'h0000_000F);
      drive(32'h0000_0000, 32'h0000_0003);
      settle();
      check("R8 class conditional multi-site", fault_class, 4);

      // R8 delay-like: suspect fails a superset
      do_clr();
      drive(32'h0000_000F, 32'h0000_00FF);
      settle();
      check("R8 class delay", fault_class, 5);
      check("R2 tot_gamma min", tot_gamma, 4);

      // R8 unexplained
      do_clr();
      drive(32'h0000_00F0, 32'h0000_00FF);
      drive(32'h0000_0100, 32'h0000_0000);
      settle();
      check("R8 class unexplained", fault_class, 6);

      // R9 after clear
      do_clr();
      @(negedge clk) check("R9 class no evidence", fault_class, 0);

      // R6 clear discards a staged pattern
      drive(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      clr = 1'b1;
      @(posedge clk); #1 clr = 1'b0;
      @(negedge clk) check("R6 staged pattern dropped", tot_alpha, 0);

      // R5 saturation
      for (int p = 0; p < 140; p++) begin
         @(posedge clk); #1;
         in_vld = 1'b1; good = '0; obs = '1; flt = '1;
      end
      @(posedge clk); #1 in_vld = 1'b0;
      settle();
      check("R5 tot_alpha saturates", tot_alpha, TMAX);
      check("R5 tot_iota untouched", tot_iota, 0);
      settle();
      check("R5 tot_alpha holds at max", tot_alpha, TMAX);

      run_cmp = 1'b0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule